// File: doc/BRIEF.md
# Serial Command Register Loader

This block takes configuration commands from a host over a three-wire serial port (an active-low select, a serial clock and a serial data line) and turns them into stable register outputs in the system clock domain. A command is one frame of 32 bits. The first two bits on the wire form an address. The other thirty carry the payload. The block keeps two configuration registers. One holds the divider settings of a clock synthesizer: an output divide select, a feedback divide value and a reference divide value. The other holds the control bits: pulse shape, trigger edge, halts, loop options, the output source and test enables. A third address stores nothing and fires a dummy trigger.

The serial lines are sampled by the system clock through synchronizers, so the serial clock must run well below the system clock. Data is taken on each rising edge of the serial clock that is detected while select is low. A frame is acted on only when select returns high, and only if exactly 32 bits were shifted in. The serial port has no back-pressure: the block accepts every frame as it arrives. A frame of the wrong length is dropped without any sign to the host.

Top module: `serial_cmd_loader`

## Requirements
- R1: After asynchronous reset (rst_n low), every register output is zero and trig_strobe is low.
- R2: Bits are taken least significant first: the first bit on the wire is address bit A0, the second is A1, then payload bits D0 to D29. The address code is {A1,A0}. Code 2'b00 loads the divider register: odiv_sel = D2..D0, fb_div = D17..D3 and ref_div = D29..D18.
- R3: Code 2'b10 loads the control register. The fields are spike_sup = D0, pulse_pol = D1, pulse_width = D3..D2, trig_edge = D4, out_src = D5, halt_all = D6, halt_vco = D7, pump_off = D8, filt_sep = D9, updn_en = D10 and test_en = D29..D11.
- R4: Code 2'b11 raises trig_strobe once after the frame is committed, and changes neither register.
- R5: Code 2'b01 changes no output and raises no strobe.
- R6: A frame whose bit count differs from 32 (for example 31 or 33) is discarded and changes no output.
- R7: Serial clock edges that arrive while select is high are not counted and shift no data.
- R8: Register outputs change only after select rises. With all 32 bits shifted and select still low, the outputs keep their old values.
- R9: trig_strobe is high for exactly one system clock cycle for each dummy trigger frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_csn | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| odiv_sel | output | 3 | Output divide select |
| fb_div | output | 15 | Feedback divide value |
| ref_div | output | 12 | Reference divide value |
| spike_sup | output | 1 | Spike suppression enable |
| pulse_pol | output | 1 | One-shot pulse polarity |
| pulse_width | output | 2 | One-shot pulse width select |
| trig_edge | output | 1 | Trigger edge select |
| out_src | output | 1 | Output source select |
| halt_all | output | 1 | Global halt |
| halt_vco | output | 1 | Oscillator halt |
| pump_off | output | 1 | Charge pump disable |
| filt_sep | output | 1 | Loop filter separate |
| updn_en | output | 1 | Phase comparator up/down output enable |
| test_en | output | 19 | Test enables |
| trig_strobe | output | 1 | Dummy trigger strobe, one cycle |

## Verification
The bench sends frames of 31 and 33 bits. A design with a loose length check would load these frames, and a design whose counter wraps would load the 33-bit one. It pulses the serial clock while select is high. A design that counts those edges would shift a misaligned frame and load wrong fields. It holds select low after the 32nd bit and then checks the outputs, which catches a design that commits on the bit count alone. It also counts strobe cycles for dummy, unused-code and real frames, which catches a strobe that lasts too long, that fires for the wrong address, or that writes a register.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int FRAME_BITS = 32;
  localparam int ADDR_BITS  = 2;
  localparam int DATA_BITS  = FRAME_BITS - ADDR_BITS;
  localparam int ODIV_W     = 3;
  localparam int FB_W       = 15;
  localparam int REF_W      = 12;
  localparam int PW_W       = 2;
  localparam int TEST_W     = 19;
  localparam int CTL_W      = 11 + TEST_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  typedef enum logic [ADDR_BITS-1:0] {
    ADR_DIV  = 2'b00,
    ADR_NONE = 2'b01,
    ADR_CTL  = 2'b10,
    ADR_TRIG = 2'b11
  } addr_e;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter
  import scl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csn_s,
  input  logic                  sclk_s,
  input  logic                  sdat_s,
  output logic                  frm_valid,
  output logic [FRAME_BITS-1:0] frm_data
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic                  sclk_d, csn_d;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] sr;
  logic                  sclk_rise, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = csn_s & ~csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      csn_d     <= 1'b1;
      cnt       <= '0;
      sr        <= '0;
      frm_valid <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      csn_d     <= csn_s;
      frm_valid <= cs_rise && (cnt == CNT_FULL);
      if (csn_s) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sr <= {sdat_s, sr[FRAME_BITS-1:1]};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frm_data = sr;

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);
  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> cnt == '0);
  assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);
endmodule

// File: rtl/scl_decode.sv
module scl_decode
  import scl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frm_valid,
  input  logic [FRAME_BITS-1:0] frm_data,
  output logic [DATA_BITS-1:0]  div_q,
  output logic [CTL_W-1:0]      ctl_q,
  output logic                  trig_strobe
);
  addr_e                addr;
  logic [DATA_BITS-1:0] pay;

  assign addr = addr_e'(frm_data[ADDR_BITS-1:0]);
  assign pay  = frm_data[FRAME_BITS-1:ADDR_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q       <= '0;
      ctl_q       <= '0;
      trig_strobe <= 1'b0;
    end else begin
      trig_strobe <= 1'b0;
      if (frm_valid) begin
        case (addr)
          ADR_DIV:  div_q <= pay;
          ADR_CTL:  ctl_q <= pay[CTL_W-1:0];
          ADR_TRIG: trig_strobe <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_strobe |=> !trig_strobe);
  assert_strobe_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_strobe |-> ($stable(div_q) && $stable(ctl_q)));
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> ($stable(div_q) && $stable(ctl_q) && !trig_strobe));
endmodule

// File: rtl/serial_cmd_loader.sv
module serial_cmd_loader
  import scl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_csn,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [ODIV_W-1:0] odiv_sel,
  output logic [FB_W-1:0]   fb_div,
  output logic [REF_W-1:0]  ref_div,
  output logic              spike_sup,
  output logic              pulse_pol,
  output logic [PW_W-1:0]   pulse_width,
  output logic              trig_edge,
  output logic              out_src,
  output logic              halt_all,
  output logic              halt_vco,
  output logic              pump_off,
  output logic              filt_sep,
  output logic              updn_en,
  output logic [TEST_W-1:0] test_en,
  output logic              trig_strobe
);
  logic [2:0]            s_q;
  logic                  frm_valid;
  logic [FRAME_BITS-1:0] frm_data;
  logic [DATA_BITS-1:0]  div_q;
  logic [CTL_W-1:0]      ctl_q;

  scl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_csn, ser_clk, ser_dat}), .q(s_q)
  );

  scl_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .csn_s(s_q[2]), .sclk_s(s_q[1]), .sdat_s(s_q[0]),
    .frm_valid(frm_valid), .frm_data(frm_data)
  );

  scl_decode u_dec (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .div_q(div_q), .ctl_q(ctl_q), .trig_strobe(trig_strobe)
  );

  assign odiv_sel    = div_q[ODIV_W-1:0];
  assign fb_div      = div_q[ODIV_W+FB_W-1:ODIV_W];
  assign ref_div     = div_q[DATA_BITS-1:ODIV_W+FB_W];
  assign spike_sup   = ctl_q[0];
  assign pulse_pol   = ctl_q[1];
  assign pulse_width = ctl_q[3:2];
  assign trig_edge   = ctl_q[4];
  assign out_src     = ctl_q[5];
  assign halt_all    = ctl_q[6];
  assign halt_vco    = ctl_q[7];
  assign pump_off    = ctl_q[8];
  assign filt_sep    = ctl_q[9];
  assign updn_en     = ctl_q[10];
  assign test_en     = ctl_q[CTL_W-1:11];
endmodule

// File: tb/serial_cmd_loader_tb.sv
module serial_cmd_loader_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_csn = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [2:0] odiv_sel; logic [14:0] fb_div; logic [11:0] ref_div;
  logic spike_sup, pulse_pol, trig_edge, out_src, halt_all, halt_vco;
  logic pump_off, filt_sep, updn_en, trig_strobe;
  logic [1:0] pulse_width; logic [18:0] test_en;

  int errors = 0, checks = 0, strobes = 0;
  logic [29:0] exp_div = '0, exp_ctl = '0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_cmd_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_csn(ser_csn), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .odiv_sel(odiv_sel), .fb_div(fb_div), .ref_div(ref_div), .spike_sup(spike_sup),
    .pulse_pol(pulse_pol), .pulse_width(pulse_width), .trig_edge(trig_edge),
    .out_src(out_src), .halt_all(halt_all), .halt_vco(halt_vco), .pump_off(pump_off),
    .filt_sep(filt_sep), .updn_en(updn_en), .test_en(test_en), .trig_strobe(trig_strobe)
  );

  always @(negedge clk) if (trig_strobe) strobes++;

  function automatic logic [31:0] mk_frame(logic [1:0] code, logic [29:0] pay);
    return {pay, code[1], code[0]};
  endfunction

  function automatic logic [29:0] act_div();
    return {ref_div, fb_div, odiv_sel};
  endfunction

  function automatic logic [29:0] act_ctl();
    return {test_en, updn_en, filt_sep, pump_off, halt_vco, halt_all, out_src,
            trig_edge, pulse_width, pulse_pol, spike_sup};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [63:0] bits, int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = bits[i];
      wclk(4); ser_clk = 1'b1;
      wclk(4); ser_clk = 1'b0;
    end
  endtask

  task automatic send(logic [63:0] bits, int n);
    ser_csn = 1'b0; wclk(4);
    shift_bits(bits, n);
    wclk(4); ser_csn = 1'b1; wclk(10);
  endtask

  task automatic model(logic [1:0] code, logic [29:0] pay, int n, output int exp_s);
    exp_s = 0;
    if (n == 32) begin
      if (code == 2'b00) exp_div = pay;
      else if (code == 2'b10) exp_ctl = pay;
      else if (code == 2'b11) exp_s = 1;
    end
  endtask

  task automatic run(string req, logic [1:0] code, logic [29:0] pay, int n);
    int s0, es;
    s0 = strobes;
    model(code, pay, n, es);
    send({32'h0, mk_frame(code, pay)}, n);
    chk({req, " div"}, {2'b0, act_div()}, {2'b0, exp_div});
    chk({req, " ctl"}, {2'b0, act_ctl()}, {2'b0, exp_ctl});
    chk({req, " strobe"}, strobes - s0, es);
  endtask

  initial begin
    wclk(150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    wclk(3);
    chk("R1 reset div", {2'b0, act_div()}, 32'h0);
    chk("R1 reset ctl", {2'b0, act_ctl()}, 32'h0);
    chk("R1 reset strobe", {31'h0, trig_strobe}, 32'h0);
    rst_n = 1'b1; wclk(4);

    // R2 directed: odiv=5, fb=0x1234, ref=0xABC
    run("R2", 2'b00, {12'hABC, 15'h1234, 3'd5}, 32);
    chk("R2 fields", {ref_div, fb_div, odiv_sel}, {2'b0, 12'hABC, 15'h1234, 3'd5});
    // R3 directed
    run("R3", 2'b10, 30'h2AAA_5555, 32);
    chk("R3 width", {30'h0, pulse_width}, 32'h1);
    // R4 dummy trigger
    run("R4", 2'b11, 30'h3FFF_FFFF, 32);
    // R5 unused code
    run("R5", 2'b01, 30'h1234_5678, 32);
    // R6 wrong lengths
    run("R6 short", 2'b00, 30'h0F0F_0F0F, 31);
    run("R6 long", 2'b10, 30'h0F0F_0F0F, 33);
    run("R6 long trig", 2'b11, 30'h0, 33);
    // R7 serial clock pulses with select high, then a good frame
    begin
      ser_dat = 1'b1;
      for (int k = 0; k < 5; k++) begin
        wclk(4); ser_clk = 1'b1; wclk(4); ser_clk = 1'b0;
      end
      wclk(4);
      run("R7", 2'b00, 30'h1357_9BDF, 32);
    end
    // R8 all bits shifted, select still low
    begin
      int s0;
      s0 = strobes;
      ser_csn = 1'b0; wclk(4);
      shift_bits({32'h0, mk_frame(2'b00, 30'h0246_8ACE)}, 32);
      wclk(12);
      chk("R8 before rise", {2'b0, act_div()}, {2'b0, exp_div});
      ser_csn = 1'b1; wclk(10);
      exp_div = 30'h0246_8ACE;
      chk("R8 after rise", {2'b0, act_div()}, {2'b0, exp_div});
      chk("R8 no strobe", strobes - s0, 0);
    end
    // R9 back to back dummy triggers
    run("R9 a", 2'b11, 30'h1, 32);
    run("R9 b", 2'b11, 30'h2, 32);
    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [1:0] code; logic [29:0] pay; int n;
      code = 2'($urandom % 4);
      pay  = 30'($urandom);
      n    = ($urandom % 6 == 0) ? (($urandom % 2) ? 31 : 33) : 32;
      run("R2/R3/R4/R5/R6 random", code, pay, n);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule